// File: doc/BRIEF.md
# Pipelined Passive Memory Parity Monitor

This block sits beside a memory bus and only listens to it. Each cycle in which the bus qualifier `bus_valid` is high, the monitor takes the address, the data word and the write flag. For a write, it computes a single even-parity bit over the word and records that bit in a private parity store at the same address. For a read, it recomputes parity over the returned word and compares it with the recorded bit. A difference sets a sticky alarm and captures the address of the first failing read. Software checks the alarm at the end of a job and clears it with a one-cycle pulse on `alarm_clr`.

The parity reduction is split across `STAGES` register stages. The address and access type travel through matching registers, so each result meets its own address. An alarm therefore appears a fixed number of cycles after the bus has already used the word. This is accepted, because the alarm only decides whether a job's output can be trusted. The monitor has no outputs toward the bus and never asserts back-pressure. `bus_valid` is a pure qualifier with no ready partner, and every qualified beat is taken in the cycle it appears.

A store entry that has not been written since reset behaves as if it holds the parity of an all-zero word (parity 0).

Top module: `parity_watch`

## Requirements
- R1: After reset, `alarm` is 0 and `alarm_addr` is 0.
- R2: A read returning exactly the word last written to that address never raises `alarm`.
- R3: Parity is even parity, the XOR of all data bits. A read whose data parity differs from the stored bit, sampled at clock edge E0, makes `alarm` rise at edge E(STAGES). `alarm` is still low after edge E(STAGES-1).
- R4: A read word that differs from the written word in an even number of bits is not detected.
- R5: Once set, `alarm` stays at 1 through later clean accesses until `alarm_clr` is applied.
- R6: A cycle with `alarm_clr` high and no arriving mismatch drives `alarm` to 0 at the next edge.
- R7: When a mismatch reaches the alarm register in the same cycle as `alarm_clr`, the mismatch wins. `alarm` stays 1 and `alarm_addr` takes that mismatch's address.
- R8: `alarm_addr` captures the address of the first mismatch after `alarm` was low. Later mismatches do not change it while `alarm` remains set.
- R9: A read of an entry not written since reset is compared against parity 0. Even-parity data passes, and odd-parity data raises `alarm`.
- R10: Accesses on consecutive cycles are all checked in order. A read issued in the cycle right after a write to the same address is compared with the parity of that write.
- R11: While `bus_valid` is 0, `bus_we`, `bus_addr` and `bus_data` have no effect. No parity is stored and no compare is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Qualifies the observed bus beat |
| bus_we | input | 1 | 1 = write beat, 0 = read beat |
| bus_addr | input | ADDR_W | Observed word address |
| bus_data | input | DATA_W | Observed write or read data |
| alarm_clr | input | 1 | Clears the sticky alarm (mismatch has priority) |
| alarm | output | 1 | Sticky parity-mismatch indicator |
| alarm_addr | output | ADDR_W | Address of the first mismatch since the last clear |

## Verification
A failing read can reach the alarm register in the same cycle as a software clear. The bench first raises the alarm at one address. It then issues a bad read at a second address and times `alarm_clr` to land exactly at the edge where that read's result arrives, STAGES cycles after the read was sampled. The outcome is judged at the ports: the alarm must still be set and the captured address must be the second one. A clear timed without such a collision must drop the alarm.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  typedef struct packed {
    logic vld;
    logic we;
  } pw_op_t;
endpackage

// File: rtl/pw_parity_pipe.sv
`timescale 1ns/1ps
module pw_parity_pipe
  import pw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pw_op_t            in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output pw_op_t            out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_par
);
  localparam int LANES = 1 << (STAGES - 1);
  localparam int GRP_W = (DATA_W + LANES - 1) / LANES;
  localparam int PAD_W = GRP_W * LANES;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(in_data);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    localparam int NL = LANES >> s;
    logic [NL-1:0]     lane;
    pw_op_t            op;
    logic [ADDR_W-1:0] addr;

    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          op   <= '0;
          addr <= '0;
        end else begin
          op   <= in_op;
          addr <= in_addr;
        end
      end
      for (genvar g = 0; g < NL; g++) begin : g_grp
        always_ff @(posedge clk) begin
          if (!rst_n) lane[g] <= 1'b0;
          else        lane[g] <= ^padded[g*GRP_W +: GRP_W];
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          op   <= '0;
          addr <= '0;
        end else begin
          op   <= g_stg[s-1].op;
          addr <= g_stg[s-1].addr;
        end
      end
      for (genvar g = 0; g < NL; g++) begin : g_pair
        always_ff @(posedge clk) begin
          if (!rst_n) lane[g] <= 1'b0;
          else        lane[g] <= g_stg[s-1].lane[2*g] ^ g_stg[s-1].lane[2*g+1];
        end
      end
    end
  end

  assign out_op   = g_stg[STAGES-1].op;
  assign out_addr = g_stg[STAGES-1].addr;
  assign out_par  = g_stg[STAGES-1].lane[0];
endmodule

// File: rtl/pw_parity_store.sv
`timescale 1ns/1ps
module pw_parity_store
  import pw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pw_op_t            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              par,
  output logic              mismatch
);
  localparam int DEPTH = 1 << ADDR_W;

  logic             par_mem [DEPTH];
  logic [DEPTH-1:0] seen_q;
  logic             stored;

  always_ff @(posedge clk) begin
    if (op.vld && op.we) par_mem[addr] <= par;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                seen_q       <= '0;
    else if (op.vld && op.we)  seen_q[addr] <= 1'b1;
  end

  assign stored   = seen_q[addr] ? par_mem[addr] : 1'b0;
  assign mismatch = op.vld && !op.we && (stored != par);

  AST_WRITE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (op.vld && op.we) |=> (seen_q[$past(addr)] && (par_mem[$past(addr)] == $past(par)))); // R10
endmodule

// File: rtl/pw_alarm.sv
`timescale 1ns/1ps
module pw_alarm #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mismatch,
  input  logic [ADDR_W-1:0] mis_addr,
  input  logic              clr,
  output logic              alarm,
  output logic [ADDR_W-1:0] alarm_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm      <= 1'b0;
      alarm_addr <= '0;
    end else if (mismatch) begin
      alarm <= 1'b1;
      if (!alarm || clr) alarm_addr <= mis_addr;
    end else if (clr) begin
      alarm <= 1'b0;
    end
  end

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> alarm); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !mismatch) |=> !alarm); // R6
  AST_MISMATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mismatch) |=> (alarm && alarm_addr == $past(mis_addr))); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> $stable(alarm_addr)); // R8
endmodule

// File: rtl/parity_watch.sv
`timescale 1ns/1ps
module parity_watch
  import pw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 6,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              alarm_clr,
  output logic              alarm,
  output logic [ADDR_W-1:0] alarm_addr
);
  pw_op_t            in_op, p_op;
  logic [ADDR_W-1:0] p_addr;
  logic              p_par;
  logic              mismatch;

  assign in_op.vld = bus_valid;
  assign in_op.we  = bus_we;

  pw_parity_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_op(in_op), .in_addr(bus_addr), .in_data(bus_data),
    .out_op(p_op), .out_addr(p_addr), .out_par(p_par)
  );

  pw_parity_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(p_op), .addr(p_addr), .par(p_par), .mismatch(mismatch)
  );

  pw_alarm #(.ADDR_W(ADDR_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .mis_addr(p_addr), .clr(alarm_clr),
    .alarm(alarm), .alarm_addr(alarm_addr)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!alarm && alarm_addr == '0)); // R1
  AST_NO_PHANTOM_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm && !mismatch) |=> !alarm); // R11
endmodule

// File: tb/sim_parity_watch.sv
`timescale 1ns/1ps
module sim_parity_watch;
  localparam int DW = 64;
  localparam int AW = 6;
  localparam int ST = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          alarm_clr = 1'b0;
  logic          alarm;
  logic [AW-1:0] alarm_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  parity_watch #(.DATA_W(DW), .ADDR_W(AW), .STAGES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_data(bus_data), .alarm_clr(alarm_clr),
    .alarm(alarm), .alarm_addr(alarm_addr)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // drive one beat at a negedge, hold through the edge; leaves us at next negedge
  task automatic put(input bit we, input int a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_we = we; bus_addr = AW'(a); bus_data = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic beat(input bit we, input int a, input logic [DW-1:0] d);
    put(we, a, d); idle();
  endtask

  task automatic drain();
    repeat (ST + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear();
    alarm_clr = 1'b1; @(posedge clk); @(negedge clk); alarm_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 alarm", alarm, 0);
    chk("R1 alarm_addr", alarm_addr, 0);
  endtask

  task automatic t_clean();
    beat(1, 5, 64'h0123_4567_89AB_CDEF);
    beat(1, 9, 64'h8000_0000_0000_0001);
    beat(0, 5, 64'h0123_4567_89AB_CDEF);
    beat(0, 9, 64'h8000_0000_0000_0001);
    drain();
    chk("R2 clean reads", alarm, 0);
  endtask

  task automatic t_latency_sticky();
    beat(1, 12, 64'hFFFF_0000_1234_5678);
    beat(1, 20, 64'h0);
    drain();
    beat(0, 12, 64'hFFFF_0000_1234_5679);       // single flip, sampled at E0
    repeat (ST - 1) @(posedge clk); @(negedge clk);
    chk("R3 low at E(STAGES-1)", alarm, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 high at E(STAGES)", alarm, 1);
    chk("R8 first addr", alarm_addr, 12);
    beat(0, 5, 64'h0123_4567_89AB_CDEF);
    drain();
    chk("R5 sticky after clean read", alarm, 1);
    beat(0, 20, 64'h10);                          // second mismatch
    drain();
    chk("R8 addr kept", alarm_addr, 12);
    clear();
    chk("R6 cleared", alarm, 0);
  endtask

  task automatic t_double_flip();
    beat(1, 30, 64'h00FF_00FF_00FF_00FF);
    beat(0, 30, 64'h00FF_00FF_00FF_00FC);         // two bits flipped
    drain();
    chk("R4 even flips pass", alarm, 0);
  endtask

  task automatic t_unwritten();
    beat(0, 40, 64'h3);
    drain();
    chk("R9 unwritten even", alarm, 0);
    beat(0, 41, 64'h1);
    drain();
    chk("R9 unwritten odd", alarm, 1);
    chk("R9 addr", alarm_addr, 41);
    clear();
  endtask

  task automatic t_back_to_back();
    put(1, 50, 64'h0);
    put(1, 50, 64'h1);
    put(0, 50, 64'h1);
    idle();
    drain();
    chk("R10 read follows latest write", alarm, 0);
    put(1, 51, 64'h7);
    put(0, 51, 64'h6);
    idle();
    drain();
    chk("R10 back-to-back mismatch", alarm, 1);
    chk("R10 addr", alarm_addr, 51);
    clear();
  endtask

  task automatic t_ignored();
    beat(1, 60, 64'h0);
    bus_valid = 1'b0; bus_we = 1'b1; bus_addr = AW'(60); bus_data = 64'h1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(61); bus_data = 64'h1;
    @(posedge clk); @(negedge clk);
    idle();
    drain();
    chk("R11 unqualified read ignored", alarm, 0);
    beat(0, 60, 64'h0);
    drain();
    chk("R11 unqualified write ignored", alarm, 0);
  endtask

  task automatic t_collide();
    beat(0, 2, 64'h1);                            // unwritten, odd -> alarm at 2
    drain();
    chk("R7 setup alarm", alarm, 1);
    beat(0, 3, 64'h1);                            // sampled at E0
    repeat (ST - 1) @(posedge clk); @(negedge clk);
    alarm_clr = 1'b1;                             // lands at E(STAGES)
    @(posedge clk); @(negedge clk);
    alarm_clr = 1'b0;
    chk("R7 alarm kept", alarm, 1);
    chk("R7 new addr", alarm_addr, 3);
    clear();
    chk("R6 plain clear", alarm, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_latency_sticky();
    t_double_flip();
    t_unwritten();
    t_back_to_back();
    t_ignored();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule